// File: doc/BRIEF.md
# Parallel Flash Bus-Cycle Decoder

This block sits on the device side of a 16-bit asynchronous/synchronous NOR-style flash bus and turns the host's active-low control strobes into decoded bus cycles inside a fast system-clock domain. Every pin goes through a two-flop synchronizer. The synchronized samples are then sorted into one of seven bus states: bus reset, standby, output disable, asynchronous read, synchronous read, write, or a conflict state in which output-enable and write-enable are both active. The decoded state drives the tri-state enables of the data bus and of the WAIT line.

Alongside the state decode, the block keeps the read-address latch. In asynchronous mode the latch follows the address bus while the address-valid strobe is low and freezes when the strobe goes high. In synchronous mode it takes the address once, on whichever comes first: a bus-clock rise with the strobe low, or the strobe's own rising edge. For writes it emits a one-cycle strobe that carries the address and data present just before the first rising edge of either write-enable or chip-enable. A core-side mode input selects synchronous or asynchronous read behaviour. The memory array supplies read data and the WAIT level through plain inputs.

Top module: `pflash_bus_decoder`

## Requirements
- R1: After system reset (`rst` high) the decoded state is 0 (bus reset), both output enables are low, the write strobe is low and the conflict flag is clear.
- R2: While the bus reset pin is low the state is 0 and neither DQ nor WAIT is enabled, whatever the other pins do.
- R3: With bus reset high and chip-enable high the state is 1 (standby) and both outputs are disabled, whatever output-enable and write-enable do.
- R4: With chip-enable low and both output-enable and write-enable high the state is 2 (output disable) and both outputs are disabled.
- R5: With chip-enable and output-enable low and write-enable high, the state is 3 when the mode input is 0 and 4 when it is 1. The DQ enable is high and DQ carries the read-data input.
- R6: WAIT is enabled only during reads. In state 4 it carries the WAIT input, and in state 3 it is held at the idle level 0.
- R7: With chip-enable and write-enable low and output-enable high the state is 5 (write) and both outputs are disabled.
- R8: Leaving a write through a rise of write-enable, chip-enable or both produces exactly one single-cycle write strobe. The strobe carries the address and data present before that rise, and a later rise of the other strobe adds no second pulse.
- R9: In asynchronous mode the latched address follows the address bus while address-valid is low and holds its value while address-valid is high.
- R10: In synchronous mode the latched address is captured once per address-valid low period, at the first bus-clock rise with address-valid low or at the address-valid rise, whichever comes first. Capture happens only while chip-enable is low and write-enable and bus reset are high.
- R11: Chip-enable, output-enable and write-enable all low gives state 6 (conflict) with both outputs disabled, and sets a conflict flag that stays set until system reset.
- R12: A change on the control pins shows on the state output at the third rising system-clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| sync_mode_i | input | 1 | 1 selects synchronous read behaviour |
| bus_rst_n_i | input | 1 | Bus reset pin, active low |
| bus_ce_n_i | input | 1 | Chip-enable pin, active low |
| bus_oe_n_i | input | 1 | Output-enable pin, active low |
| bus_we_n_i | input | 1 | Write-enable pin, active low |
| bus_adv_n_i | input | 1 | Address-valid pin, active low |
| bus_clk_i | input | 1 | Bus clock pin |
| bus_addr_i | input | AW | Address bus |
| bus_dq_i | input | DW | Data bus input side |
| rd_data_i | input | DW | Read data from the array |
| wait_i | input | 1 | WAIT level from the array for synchronous reads |
| dq_o | output | DW | Data bus output side |
| dq_oe_o | output | 1 | Data bus tri-state enable |
| wait_o | output | 1 | WAIT output value |
| wait_oe_o | output | 1 | WAIT tri-state enable |
| addr_o | output | AW | Latched read address |
| wr_stb_o | output | 1 | One-cycle write capture strobe |
| wr_addr_o | output | AW | Captured write address |
| wr_data_o | output | DW | Captured write data |
| state_o | output | 3 | Decoded bus state code |
| conflict_err_o | output | 1 | Sticky output/write-enable conflict flag |

## Verification
The hardest situations to reach are the edge races. One is a write that ends when chip-enable rises while write-enable is still low, with the data bus changing on that same edge. The other is a synchronous address capture in which a second bus-clock rise or a new address arrives after the first capture but while address-valid is still low. The bench drives these from directed sequences. The pins move at the falling system-clock edge, so the two strobes and the data change in the same synchronizer cycle. A falling-edge monitor counts every write strobe, which exposes both duplicate pulses and missing ones.

// File: rtl/pfbd_pkg.sv
package pfbd_pkg;

  typedef enum logic [2:0] {
    ST_BUS_RESET = 3'd0,
    ST_STANDBY   = 3'd1,
    ST_OUT_DIS   = 3'd2,
    ST_RD_ASYNC  = 3'd3,
    ST_RD_SYNC   = 3'd4,
    ST_WRITE     = 3'd5,
    ST_CONFLICT  = 3'd6
  } bus_state_e;

  typedef struct packed {
    logic rst_n;
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic adv_n;
    logic bclk;
  } bus_ctl_t;

  // Idle pin image: bus held in reset, strobes inactive, bus clock low.
  localparam bus_ctl_t CTL_IDLE = '{rst_n: 1'b0, ce_n: 1'b1, oe_n: 1'b1,
                                    we_n: 1'b1, adv_n: 1'b1, bclk: 1'b0};

endpackage

// File: rtl/pfbd_sync.sv
module pfbd_sync #(
  parameter int           W      = 1,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] INIT   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pfbd_classify.sv
module pfbd_classify
  import pfbd_pkg::*;
(
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic       sync_mode,
  output bus_state_e state
);

  // Priority: bus reset, chip deselect, strobe conflict, write, read, idle.
  always_comb begin
    if (!rst_n)             state = ST_BUS_RESET;
    else if (ce_n)          state = ST_STANDBY;
    else if (!oe_n && !we_n) state = ST_CONFLICT;
    else if (!we_n)         state = ST_WRITE;
    else if (!oe_n)         state = sync_mode ? ST_RD_SYNC : ST_RD_ASYNC;
    else                    state = ST_OUT_DIS;
  end

endmodule

// File: rtl/pfbd_addr_latch.sv
module pfbd_addr_latch #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_mode,
  input  logic          rst_n_s,
  input  logic          ce_n_s,
  input  logic          we_n_s,
  input  logic          adv_n_s,
  input  logic          adv_n_p,
  input  logic          bclk_s,
  input  logic          bclk_p,
  input  logic [AW-1:0] addr_s,
  input  logic [AW-1:0] addr_p,
  output logic [AW-1:0] addr_o
);

  logic          taken_q;
  logic [AW-1:0] addr_q;
  logic          gate_ok;
  logic          clk_evt;
  logic          adv_evt;

  assign gate_ok = rst_n_s && !ce_n_s && we_n_s;
  assign clk_evt = bclk_s && !bclk_p && !adv_n_s;
  assign adv_evt = adv_n_s && !adv_n_p;

  always_ff @(posedge clk) begin
    if (rst || !rst_n_s) begin
      addr_q  <= '0;
      taken_q <= 1'b0;
    end else if (!sync_mode) begin
      taken_q <= 1'b0;
      if (!adv_n_s) addr_q <= addr_s;
    end else begin
      if (adv_n_s) taken_q <= 1'b0;
      if (gate_ok && !taken_q) begin
        if (adv_evt) begin
          addr_q <= addr_p;
        end else if (clk_evt) begin
          addr_q  <= addr_s;
          taken_q <= 1'b1;
        end
      end
    end
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/pfbd_wr_capture.sv
module pfbd_wr_capture #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rst_n_p,
  input  logic          ce_n_p,
  input  logic          oe_n_p,
  input  logic          we_n_p,
  input  logic          rst_n_s,
  input  logic          ce_n_s,
  input  logic          we_n_s,
  input  logic [AW-1:0] addr_p,
  input  logic [DW-1:0] dq_p,
  output logic          stb_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);

  logic          in_write_p;
  logic          closing;
  logic          stb_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign in_write_p = rst_n_p && !ce_n_p && oe_n_p && !we_n_p;
  assign closing    = rst_n_s && (we_n_s || ce_n_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      stb_q <= in_write_p && closing;
      if (in_write_p && closing) begin
        addr_q <= addr_p;
        data_q <= dq_p;
      end
    end
  end

  assign stb_o  = stb_q;
  assign addr_o = addr_q;
  assign data_o = data_q;

endmodule

// File: rtl/pflash_bus_decoder.sv
module pflash_bus_decoder
  import pfbd_pkg::*;
#(
  parameter int   AW          = 24,
  parameter int   DW          = 16,
  parameter int   SYNC_STAGES = 2,
  parameter logic WAIT_IDLE   = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_mode_i,
  input  logic          bus_rst_n_i,
  input  logic          bus_ce_n_i,
  input  logic          bus_oe_n_i,
  input  logic          bus_we_n_i,
  input  logic          bus_adv_n_i,
  input  logic          bus_clk_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_dq_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic          wait_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic          wait_o,
  output logic          wait_oe_o,
  output logic [AW-1:0] addr_o,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic [2:0]    state_o,
  output logic          conflict_err_o
);

  localparam int CW = $bits(bus_ctl_t);

  bus_ctl_t      ctl_raw, ctl_s, ctl_p;
  logic [AW-1:0] addr_s, addr_p;
  logic [DW-1:0] dq_s, dq_p;
  bus_state_e    state_d;
  logic          read_d;

  assign ctl_raw = '{rst_n: bus_rst_n_i, ce_n: bus_ce_n_i, oe_n: bus_oe_n_i,
                     we_n: bus_we_n_i, adv_n: bus_adv_n_i, bclk: bus_clk_i};

  pfbd_sync #(.W(CW), .STAGES(SYNC_STAGES), .INIT(CTL_IDLE)) u_sync_ctl (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
  );
  pfbd_sync #(.W(AW), .STAGES(SYNC_STAGES), .INIT('0)) u_sync_addr (
    .clk(clk), .rst(rst), .d(bus_addr_i), .q(addr_s)
  );
  pfbd_sync #(.W(DW), .STAGES(SYNC_STAGES), .INIT('0)) u_sync_dq (
    .clk(clk), .rst(rst), .d(bus_dq_i), .q(dq_s)
  );

  // One-cycle history of the synchronized samples for edge detection.
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_p  <= CTL_IDLE;
      addr_p <= '0;
      dq_p   <= '0;
    end else begin
      ctl_p  <= ctl_s;
      addr_p <= addr_s;
      dq_p   <= dq_s;
    end
  end

  pfbd_classify u_classify (
    .rst_n(ctl_s.rst_n), .ce_n(ctl_s.ce_n), .oe_n(ctl_s.oe_n),
    .we_n(ctl_s.we_n), .sync_mode(sync_mode_i), .state(state_d)
  );

  pfbd_addr_latch #(.AW(AW)) u_addr_latch (
    .clk(clk), .rst(rst), .sync_mode(sync_mode_i),
    .rst_n_s(ctl_s.rst_n), .ce_n_s(ctl_s.ce_n), .we_n_s(ctl_s.we_n),
    .adv_n_s(ctl_s.adv_n), .adv_n_p(ctl_p.adv_n),
    .bclk_s(ctl_s.bclk), .bclk_p(ctl_p.bclk),
    .addr_s(addr_s), .addr_p(addr_p), .addr_o(addr_o)
  );

  pfbd_wr_capture #(.AW(AW), .DW(DW)) u_wr_capture (
    .clk(clk), .rst(rst),
    .rst_n_p(ctl_p.rst_n), .ce_n_p(ctl_p.ce_n), .oe_n_p(ctl_p.oe_n),
    .we_n_p(ctl_p.we_n), .rst_n_s(ctl_s.rst_n), .ce_n_s(ctl_s.ce_n),
    .we_n_s(ctl_s.we_n), .addr_p(addr_p), .dq_p(dq_p),
    .stb_o(wr_stb_o), .addr_o(wr_addr_o), .data_o(wr_data_o)
  );

  assign read_d = (state_d == ST_RD_ASYNC) || (state_d == ST_RD_SYNC);

  // Registered pin-side outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_o        <= ST_BUS_RESET;
      dq_oe_o        <= 1'b0;
      dq_o           <= '0;
      wait_oe_o      <= 1'b0;
      wait_o         <= WAIT_IDLE;
      conflict_err_o <= 1'b0;
    end else begin
      state_o   <= state_d;
      dq_oe_o   <= read_d;
      dq_o      <= read_d ? rd_data_i : '0;
      wait_oe_o <= read_d;
      wait_o    <= (state_d == ST_RD_SYNC) ? wait_i : WAIT_IDLE;
      if (state_d == ST_CONFLICT) conflict_err_o <= 1'b1;
    end
  end

endmodule

// File: rtl/pfbd_checker.sv
module pfbd_checker
  import pfbd_pkg::*;
#(
  parameter logic WAIT_IDLE = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] state_o,
  input logic       dq_oe_o,
  input logic       wait_oe_o,
  input logic       wait_o,
  input logic       wr_stb_o,
  input logic       conflict_err_o
);

  assert_reset_hiz_R2: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_BUS_RESET) |-> (!dq_oe_o && !wait_oe_o));

  assert_drive_only_in_read_R5: assert property (@(posedge clk) disable iff (rst)
    dq_oe_o |-> (state_o == ST_RD_ASYNC || state_o == ST_RD_SYNC));

  assert_async_wait_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_RD_ASYNC) |-> (wait_oe_o && wait_o == WAIT_IDLE));

  assert_write_hiz_R7: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_WRITE) |-> (!dq_oe_o && !wait_oe_o));

  assert_single_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |=> !wr_stb_o);

  assert_conflict_flags_R11: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_CONFLICT) |-> conflict_err_o);

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    conflict_err_o |=> conflict_err_o);

endmodule

bind pflash_bus_decoder pfbd_checker #(.WAIT_IDLE(WAIT_IDLE)) u_pfbd_checker (
  .clk(clk), .rst(rst), .state_o(state_o), .dq_oe_o(dq_oe_o),
  .wait_oe_o(wait_oe_o), .wait_o(wait_o), .wr_stb_o(wr_stb_o),
  .conflict_err_o(conflict_err_o)
);

// File: tb/pflash_bus_decoder_bench.sv
module pflash_bus_decoder_bench;

  localparam int AW = 24;
  localparam int DW = 16;
  localparam logic [DW-1:0] RD_WORD = 16'hA5C3;

  // Vector: [9] rst_n [8] ce_n [7] oe_n [6] we_n [5] mode [4:2] state [1] dq_oe [0] wait_oe
  localparam int NV = 10;
  localparam logic [9:0] VEC [NV] = '{
    10'b0_1_0_1_0_000_0_0,
    10'b0_0_0_1_1_000_0_0,
    10'b1_1_0_1_0_001_0_0,
    10'b1_1_1_0_1_001_0_0,
    10'b1_0_1_1_0_010_0_0,
    10'b1_0_0_1_0_011_1_1,
    10'b1_0_0_1_1_100_1_1,
    10'b1_0_1_0_0_101_0_0,
    10'b1_0_1_0_1_101_0_0,
    10'b1_0_1_1_1_010_0_0
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          sync_mode;
  logic          p_rst_n, p_ce_n, p_oe_n, p_we_n, p_adv_n, p_bclk;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_dq;
  logic [DW-1:0] rd_data;
  logic          wait_in;
  logic [DW-1:0] dq_o;
  logic          dq_oe_o, wait_o, wait_oe_o, wr_stb_o, conflict_err_o;
  logic [AW-1:0] addr_o, wr_addr_o;
  logic [DW-1:0] wr_data_o;
  logic [2:0]    state_o;

  int n_chk  = 0;
  int n_fail = 0;
  int stb_cnt = 0;
  logic [AW-1:0] cap_a;
  logic [DW-1:0] cap_d;

  always #4 clk = ~clk;

  pflash_bus_decoder #(.AW(AW), .DW(DW)) u_pflash_bus_decoder (
    .clk(clk), .rst(rst), .sync_mode_i(sync_mode),
    .bus_rst_n_i(p_rst_n), .bus_ce_n_i(p_ce_n), .bus_oe_n_i(p_oe_n),
    .bus_we_n_i(p_we_n), .bus_adv_n_i(p_adv_n), .bus_clk_i(p_bclk),
    .bus_addr_i(p_addr), .bus_dq_i(p_dq), .rd_data_i(rd_data), .wait_i(wait_in),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o), .wait_o(wait_o), .wait_oe_o(wait_oe_o),
    .addr_o(addr_o), .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .state_o(state_o), .conflict_err_o(conflict_err_o)
  );

  always @(negedge clk) begin
    if (wr_stb_o) begin
      stb_cnt <= stb_cnt + 1;
      cap_a   <= wr_addr_o;
      cap_d   <= wr_data_o;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pins(input logic r, input logic c, input logic o, input logic w);
    p_rst_n = r; p_ce_n = c; p_oe_n = o; p_we_n = w;
  endtask

  function automatic string tag_of(input logic [2:0] s);
    case (s)
      3'd0: return "R2 bus reset";
      3'd1: return "R3 standby";
      3'd2: return "R4 output disable";
      3'd5: return "R7 write";
      default: return "R5 read";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; sync_mode = 1'b0;
    pins(1'b0, 1'b1, 1'b1, 1'b1);
    p_adv_n = 1'b1; p_bclk = 1'b0; p_addr = '0; p_dq = '0;
    rd_data = RD_WORD; wait_in = 1'b1;
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk("R1 state", state_o, 0);
    chk("R1 dq_oe", dq_oe_o, 0);
    chk("R1 wait_oe", wait_oe_o, 0);
    chk("R1 strobe", wr_stb_o, 0);
    chk("R1 flag", conflict_err_o, 0);

    // Table walk over pin combinations
    for (int i = 0; i < NV; i++) begin
      pins(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6]);
      sync_mode = VEC[i][5];
      step(5);
      chk(tag_of(VEC[i][4:2]), state_o, VEC[i][4:2]);
      chk(tag_of(VEC[i][4:2]), dq_oe_o, VEC[i][1]);
      chk("R6 wait enable", wait_oe_o, VEC[i][0]);
      if (VEC[i][1]) begin
        chk("R5 read data", dq_o, RD_WORD);
        chk("R6 wait level", wait_o, VEC[i][5] ? wait_in : 1'b0);
      end
    end
    wait_in = 1'b0;
    sync_mode = 1'b1; pins(1'b1, 1'b0, 1'b0, 1'b1);
    step(5);
    chk("R6 sync wait follows input", wait_o, 0);

    // R12 latency
    pins(1'b1, 1'b1, 1'b1, 1'b1); sync_mode = 1'b0;
    step(5);
    pins(1'b1, 1'b0, 1'b0, 1'b1);
    step(2);
    chk("R12 before third edge", state_o, 1);
    step(1);
    chk("R12 at third edge", state_o, 3);

    // R9 asynchronous address flow and hold
    pins(1'b1, 1'b0, 1'b1, 1'b1);
    p_adv_n = 1'b0; p_addr = 24'h000123;
    step(5); chk("R9 flow", addr_o, 24'h000123);
    p_addr = 24'h000456;
    step(5); chk("R9 flow update", addr_o, 24'h000456);
    p_adv_n = 1'b1; step(1); p_addr = 24'h000789;
    step(5); chk("R9 hold", addr_o, 24'h000456);

    // R10 synchronous capture
    sync_mode = 1'b1; p_adv_n = 1'b0; p_addr = 24'h0A0A0A;
    step(5); chk("R10 no flow", addr_o, 24'h000456);
    p_bclk = 1'b1; step(3); p_bclk = 1'b0;
    step(5); chk("R10 clk capture", addr_o, 24'h0A0A0A);
    p_addr = 24'h0B0B0B;
    p_bclk = 1'b1; step(3); p_bclk = 1'b0;
    step(5); chk("R10 first event only", addr_o, 24'h0A0A0A);
    p_adv_n = 1'b1; step(5);
    chk("R10 held on strobe rise", addr_o, 24'h0A0A0A);
    p_adv_n = 1'b0; p_addr = 24'h0C0C0C; step(5);
    p_adv_n = 1'b1; step(5);
    chk("R10 strobe rise capture", addr_o, 24'h0C0C0C);
    pins(1'b1, 1'b0, 1'b1, 1'b0);
    p_adv_n = 1'b0; p_addr = 24'h0D0D0D; step(5);
    p_bclk = 1'b1; step(3); p_bclk = 1'b0; step(5);
    chk("R10 gated by write", addr_o, 24'h0C0C0C);
    p_adv_n = 1'b1; pins(1'b1, 1'b0, 1'b1, 1'b1); sync_mode = 1'b0;
    step(6);

    // R8 write capture
    stb_cnt = 0;
    p_addr = 24'h001111; p_dq = 16'h1234; pins(1'b1, 1'b0, 1'b1, 1'b0);
    step(5);
    p_we_n = 1'b1; step(6);
    chk("R8 we rise count", stb_cnt, 1);
    chk("R8 we rise addr", cap_a, 24'h001111);
    chk("R8 we rise data", cap_d, 16'h1234);
    p_ce_n = 1'b1; step(6);
    chk("R8 no second pulse", stb_cnt, 1);
    p_addr = 24'h002222; p_dq = 16'hBEEF; pins(1'b1, 1'b0, 1'b1, 1'b0);
    step(5);
    p_ce_n = 1'b1; p_dq = 16'h0F0F; step(6);
    chk("R8 ce rise count", stb_cnt, 2);
    chk("R8 ce rise data", cap_d, 16'hBEEF);
    p_we_n = 1'b1; step(6);
    chk("R8 late we rise", stb_cnt, 2);
    p_addr = 24'h003333; p_dq = 16'h5A5A; pins(1'b1, 1'b0, 1'b1, 1'b0);
    step(5);
    p_ce_n = 1'b1; p_we_n = 1'b1; step(6);
    chk("R8 joint rise count", stb_cnt, 3);
    chk("R8 joint rise addr", cap_a, 24'h003333);

    // R11 conflict and sticky flag
    pins(1'b1, 1'b0, 1'b0, 1'b0); step(5);
    chk("R11 conflict state", state_o, 6);
    chk("R11 conflict hiz", dq_oe_o, 0);
    chk("R11 flag set", conflict_err_o, 1);
    pins(1'b1, 1'b0, 1'b1, 1'b1); step(5);
    chk("R11 flag sticky", conflict_err_o, 1);
    rst = 1'b1; step(2); rst = 1'b0; step(1);
    chk("R11 flag cleared by reset", conflict_err_o, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule